// File: doc/BRIEF.md
# Left-Justified to Simultaneous Audio Converter

This block takes a stereo serial audio stream in left-justified form (24-bit words in 32-bit slots, 64 bit clocks per sample frame) and re-times it for a 16-bit converter that loads both channels in parallel. The input bit clock is the block's clock. Word select high carries the left word and word select low carries the right word. Each word's first bit is its MSB.

Inside the block, the MSB of every word is inverted as it passes, which turns two's complement into offset binary. The corrected stream is registered once and drives the right data line. A 32-stage shift line delays the same stream to drive the left data line, so both channels leave on the same clock edges. A burst window opens for the first 16 bit periods of the low half of each frame. Data, bit clock and their companions are forced inactive outside it, which drops the lower 8 bits of every 24-bit word. Word select is passed through unchanged as the latch strobe for the converter.

Top module: `lj_sim_conv`

## Requirements
- R1: The latch output `latch_o` always equals the live `ws_i` input.
- R2: The first bit of every word, meaning the bit sampled on the first rising clock edge after `ws_i` changes, comes out inverted on the data lines.
- R3: Bits 2 to 16 of each word (word bits 22 down to 8) come out unchanged.
- R4: After the rising edge that samples bit k (k = 0..15) of the right word, `right_o` carries that bit. `left_o` carries bit k of the left word that was sent 32 edges earlier, in the preceding high half.
- R5: `win_o` is high for exactly the 16 clock periods that follow the first 16 rising edges sampling `ws_i` low. It is low everywhere else, including the whole high half.
- R6: Whenever `win_o` is low, `left_o`, `right_o` and `bck_o` are low, `bck_n_o` is high, and `win_n_o` is high.
- R7: Inside the window, `bck_o` follows the clock and `bck_n_o` is its complement.
- R8: Word bits 7 to 0 and the 8 padding bits of every slot never reach any output.
- R9: While `rst` is high, and after it is released until `ws_i` has been sampled high once, `win_o`, `left_o`, `right_o` and `bck_o` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input bit clock (64 per frame), rising-edge sampling |
| rst | input | 1 | Synchronous active-high reset |
| sd_i | input | 1 | Serial data, MSB first, left-justified |
| ws_i | input | 1 | Word select: 1 = left word, 0 = right word |
| left_o | output | 1 | Gated left-channel data, offset binary |
| right_o | output | 1 | Gated right-channel data, offset binary |
| bck_o | output | 1 | Bit clock gated to the 16-bit burst |
| bck_n_o | output | 1 | Complement of `bck_o` |
| win_o | output | 1 | Burst window, high for 16 bit periods |
| win_n_o | output | 1 | Complement of `win_o` |
| latch_o | output | 1 | Latch strobe, a copy of word select |

## Verification
The bench sends whole frames made from fixed extremes (all zeros, all ones, full-scale positive and negative, alternating bits) and then from single walking ones across the top 16 bits of each channel. These separate MSB inversion from plain passing and show any bit reordering or left/right swap. A run of pseudo-random words with random low bytes and padding checks that everything below the top 16 bits is dropped. A reset in the middle of a frame, followed by a stretch of low word select, checks that nothing appears before the first complete frame.

// File: rtl/lj_sim_pkg.sv
package lj_sim_pkg;
    parameter int SLOT_BITS = 32;
    parameter int OUT_BITS  = 16;
    localparam int CNT_W    = $clog2(OUT_BITS + 2);

    typedef struct packed {
        logic left;
        logic right;
    } chan_pair_t;

    typedef struct packed {
        logic open;
        logic shut;
    } win_pair_t;

    function automatic logic flip_if(input logic bit_in, input logic ctrl);
        return bit_in ^ ctrl;
    endfunction
endpackage

// File: rtl/lj_msb_fix.sv
module lj_msb_fix (
    input  logic clk,
    input  logic rst,
    input  logic sd_i,
    input  logic ws_i,
    output logic ws_q,
    output logic data_q
);
    import lj_sim_pkg::*;

    logic first_bit;

    assign first_bit = ws_i ^ ws_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ws_q   <= 1'b0;
            data_q <= 1'b0;
        end else begin
            ws_q   <= ws_i;
            data_q <= flip_if(sd_i, first_bit);
        end
    end

    p_msb_invert_r2: assert property (@(posedge clk) disable iff (rst)
        first_bit |=> (data_q == !$past(sd_i)));
    p_bit_pass_r3: assert property (@(posedge clk) disable iff (rst)
        !first_bit |=> (data_q == $past(sd_i)));
endmodule

// File: rtl/lj_chan_delay.sv
module lj_chan_delay #(
    parameter int DEPTH = lj_sim_pkg::SLOT_BITS
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic d_o
);
    logic [DEPTH-1:0] line_q;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) line_q[g] <= 1'b0;
                    else     line_q[g] <= d_i;
                end
            end else begin : g_body
                always_ff @(posedge clk) begin
                    if (rst) line_q[g] <= 1'b0;
                    else     line_q[g] <= line_q[g-1];
                end
            end
        end
    endgenerate

    assign d_o = line_q[DEPTH-1];

    p_shift_tail_r4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (d_o == $past(line_q[DEPTH-2])));
endmodule

// File: rtl/lj_burst_window.sv
module lj_burst_window (
    input  logic clk,
    input  logic rst,
    input  logic ws_i,
    input  logic ws_q,
    output logic win
);
    import lj_sim_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic             seen_q;
    logic             term;

    assign term = (cnt_q > CNT_W'(OUT_BITS));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            seen_q <= seen_q | ws_i;
            if (ws_i)       cnt_q <= '0;
            else if (!term) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign win = seen_q & ~(term | ws_q);

    p_no_win_left_r5: assert property (@(posedge clk) disable iff (rst)
        ws_q |-> !win);
    p_term_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (term && !ws_i) |=> term);
    p_win_after_low_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(win) |-> !$past(ws_i));
endmodule

// File: rtl/lj_sim_conv.sv
module lj_sim_conv (
    input  logic clk,
    input  logic rst,
    input  logic sd_i,
    input  logic ws_i,
    output logic left_o,
    output logic right_o,
    output logic bck_o,
    output logic bck_n_o,
    output logic win_o,
    output logic win_n_o,
    output logic latch_o
);
    import lj_sim_pkg::*;

    logic       ws_q;
    logic       data_q;
    logic       win;
    chan_pair_t raw;
    win_pair_t  wp;

    lj_msb_fix i_msb (
        .clk    (clk),
        .rst    (rst),
        .sd_i   (sd_i),
        .ws_i   (ws_i),
        .ws_q   (ws_q),
        .data_q (data_q)
    );

    lj_chan_delay #(.DEPTH(SLOT_BITS)) i_left_dly (
        .clk (clk),
        .rst (rst),
        .d_i (data_q),
        .d_o (raw.left)
    );

    assign raw.right = data_q;

    lj_burst_window i_win (
        .clk  (clk),
        .rst  (rst),
        .ws_i (ws_i),
        .ws_q (ws_q),
        .win  (win)
    );

    assign wp.open = win;
    assign wp.shut = ~win;

    assign left_o  = raw.left  & wp.open;
    assign right_o = raw.right & wp.open;
    assign bck_o   = clk & wp.open;
    assign bck_n_o = ~bck_o;
    assign win_o   = wp.open;
    assign win_n_o = wp.shut;
    assign latch_o = ws_i;

    p_quiet_reset_r9: assert property (@(posedge clk)
        rst |=> !win_o);
endmodule

// File: tb/test_lj_sim_conv.sv
module test_lj_sim_conv;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sd = 1'b0;
    logic ws = 1'b0;
    logic left_o, right_o, bck_o, bck_n_o, win_o, win_n_o, latch_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    lj_sim_conv i_lj_sim_conv (
        .clk(clk), .rst(rst), .sd_i(sd), .ws_i(ws),
        .left_o(left_o), .right_o(right_o), .bck_o(bck_o), .bck_n_o(bck_n_o),
        .win_o(win_o), .win_n_o(win_n_o), .latch_o(latch_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    task automatic idle_checks(input string req);
        chk({req, " win"}, win_o, 1'b0);
        chk({req, " win_n"}, win_n_o, 1'b1);
        chk({req, " left"}, left_o, 1'b0);
        chk({req, " right"}, right_o, 1'b0);
        chk({req, " bck"}, bck_o, 1'b0);
        chk({req, " bck_n"}, bck_n_o, 1'b1);
    endtask

    // One 64-bit frame: left slot (ws high) then right slot (ws low).
    task automatic send_frame(input logic [23:0] lw, input logic [23:0] rw);
        logic [15:0] el, er;
        el = lw[23:8] ^ 16'h8000;   // R2 MSB inverted, R3 rest passed, R8 low byte dropped
        er = rw[23:8] ^ 16'h8000;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            ws = (i < 32);
            if ((i % 32) < 24) sd = (i < 32) ? lw[23 - (i % 32)] : rw[23 - (i % 32)];
            else               sd = next_rand();   // R8 padding noise
            @(posedge clk);
            #2;
            chk("R1 latch", latch_o, ws);
            if (i >= 32 && (i - 32) < 16) begin
                chk("R5 win", win_o, 1'b1);
                chk("R6 win_n", win_n_o, 1'b0);
                chk("R4 right data", right_o, er[15 - (i - 32)]);
                chk("R4 left data", left_o, el[15 - (i - 32)]);
                chk("R7 bck", bck_o, 1'b1);
                chk("R7 bck_n", bck_n_o, 1'b0);
            end else begin
                idle_checks("R6 idle");
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        idle_checks("R9 reset");
        @(negedge clk);
        rst = 1'b0;
        // ws low, no high seen yet: outputs stay quiet (R9)
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); sd = next_rand();
            @(posedge clk); #2;
            idle_checks("R9 pre-frame");
        end
        // extremes (R2, R3)
        send_frame(24'h000000, 24'h000000);
        send_frame(24'hFFFFFF, 24'hFFFFFF);
        send_frame(24'h7FFFFF, 24'h800000);
        send_frame(24'h800000, 24'h7FFFFF);
        send_frame(24'hAAAAAA, 24'h555555);
        // walking ones in the top 16 bits, opposite directions on L and R (R4)
        for (int b = 0; b < 16; b++)
            send_frame(24'h000100 << b, 24'h800000 >> b);
        // random words with random low bytes (R8)
        for (int f = 0; f < 20; f++) begin
            logic [23:0] a, c;
            for (int k = 0; k < 24; k++) begin a[k] = next_rand(); c[k] = next_rand(); end
            send_frame(a, c);
        end
        // reset mid-frame (R9)
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); ws = 1'b1; sd = next_rand();
        end
        @(negedge clk); rst = 1'b1; ws = 1'b0;
        @(posedge clk); #2;
        idle_checks("R9 mid reset");
        @(negedge clk); rst = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); sd = next_rand();
            @(posedge clk); #2;
            idle_checks("R9 after reset");
        end
        send_frame(24'h123456, 24'hFEDCBA);
        send_frame(24'h8001FF, 24'h7FFE00);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule